// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block drives the external memory bus of an 8-bit controller core in which one machine cycle is twelve oscillator clocks. The core hands over one transfer per machine cycle: a two-byte program fetch, a data read or a data write, with a 16-bit address and, for writes, one data byte. The sequencer turns the transfer into fixed waveforms, each edge at a set oscillator-clock slot. These waveforms are an address latch strobe, an active-low program-store strobe, active-low read and write strobes, a multiplexed low address/data port and a high address port. It returns the fetched or read bytes to the core with a one-clock completion pulse.

An internal phase counter runs from 0 to 11 without stopping. A request is taken only on the clock edge that ends phase 11, and the transfer then occupies phases 0 to 11 of the next machine cycle. When no transfer is taken the cycle is idle. The latch strobe then keeps pulsing twice per machine cycle, at one sixth of the oscillator rate, unless the quiet input is high. The low port is split into an output byte with an enable and a separate input byte. The pad that merges them lies outside this block.

Cycle kinds are coded on `req_kind`: 00 program fetch, 01 data read, 10 data write, 11 reserved (treated as no request).

Top module: `ext_bus_seq`

## Requirements
- R1: The phase counter is 0 in the first clock after reset is released and counts 0..11 repeatedly. `req_ready` is high only in phase 11, so it is first seen high 11 clocks after reset release and then once every 12 clocks.
- R2: While `rst` is high, `psen_n`, `rd_n` and `wr_n` are 1 and `done` and `ad_oe` are 0.
- R3: With `ale_quiet` low, `ale` is high in phases 0–1 and 6–7 of fetch and idle cycles, and in phases 0–1 only of read and write cycles. It is low in all other phases.
- R4: In a fetch cycle for address A, `psen_n` is low in phases 3–5 and 9–11. `ad_out` carries A[7:0] in phases 0–2 and (A+1)[7:0] in phases 6–8, with `ad_oe` high there and low in the other phases. The byte on `ad_in` at the end of phase 5 becomes `rdata[7:0]`, and the byte at the end of phase 11 becomes `rdata[15:8]`.
- R5: In a read cycle, `rd_n` is low in phases 5–10 and `ad_oe` is high only in phases 0–2, where it carries A[7:0]. The byte on `ad_in` at the end of phase 10 is returned as `rdata = {8'h00, byte}`.
- R6: In a write cycle, `wr_n` is low in phases 5–10. `ad_out` carries A[7:0] in phases 0–2 and the write byte in phases 4–11, with `ad_oe` high in those phases and low in phase 3.
- R7: `ahi_out` carries A[15:8] for the whole cycle, except in phases 6–11 of a fetch, where it carries (A+1)[15:8]. Idle cycles hold the high byte of the last accepted address, which is 0 after reset.
- R8: With `ale_quiet` high, `ale` stays low through idle cycles. Fetch, read and write cycles still pulse it exactly as in R3.
- R9: `req_valid`, `req_kind`, `req_addr` and `req_wdata` are sampled only on the edge ending phase 11. A request held in any other phase, or one with kind 11, starts no transfer, and that cycle is idle.
- R10: `done` is high for exactly the one clock of phase 0 that follows each fetch, read or write cycle, and never after an idle cycle. `rdata` is valid while `done` is high.
- R11: At most one of `psen_n`, `rd_n`, `wr_n` is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_quiet | input | 1 | Suppress latch strobe in idle cycles |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | High in phase 11, when a request is taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Fetched bytes {A+1, A} or {00, read byte} |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low port output: A[7:0] or write data |
| ad_oe | output | 1 | Low port output enable |
| ad_in | input | 8 | Low port input from the pad |
| ahi_out | output | 8 | High address port |

## Verification
The bench drives `ad_in` with the correct byte only in the exact sampling phase and with a decoy byte in the phases around it. A design that samples one clock early or late returns the decoy in `rdata`. A fetch at 12FF checks that the second half carries 13 on the high port and 00 on the low port. A design that increments only the low byte, or never switches address halfway, shows up there. Requests held through the middle of a cycle, and the reserved kind, must leave the bus idle, with `wr_n` high and no `done`. Idle cycles with the quiet input set must show no latch strobe, while access cycles under the same setting must still pulse it; a design that gates the strobe unconditionally loses its address latch.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    // machine cycle geometry
    localparam int PH_N    = 12;
    localparam int PH_W    = $clog2(PH_N);
    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int KIND_W  = 2;

    // slot positions within the machine cycle (oscillator clocks)
    localparam int ALE_A    = 0;   // first latch pulse
    localparam int ALE_B    = 6;   // second latch pulse
    localparam int ALE_LEN  = 2;
    localparam int ADR_LEN  = 3;   // low address held on low port
    localparam int PSEN_A   = 3;
    localparam int PSEN_B   = 9;
    localparam int PSEN_LEN = 3;
    localparam int STB_AT   = 5;   // read/write strobe start
    localparam int STB_LEN  = 6;
    localparam int WD_AT    = 4;   // write data launch
    localparam int WD_LEN   = PH_N - WD_AT;

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

    typedef enum logic [KIND_W-1:0] {
        CYC_FETCH = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10,
        CYC_IDLE  = 2'b11
    } cyc_e;

    typedef struct packed {
        cyc_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } xfer_t;

    function automatic logic in_win(input logic [PH_W-1:0] p, input int start, input int len);
        return (int'(p) >= start) && (int'(p) < start + len);
    endfunction

    function automatic logic is_last(input logic [PH_W-1:0] p, input int start, input int len);
        return int'(p) == start + len - 1;
    endfunction
endpackage

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr
    import ebus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    assign last = (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || last) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        last |=> (phase == '0)); // R1
endmodule

// File: rtl/ebus_xfer_ctl.sv
module ebus_xfer_ctl
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase,
    input  logic              last,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [BYTE_W-1:0] ad_in,
    output xfer_t             cur,
    output logic              done,
    output logic [2*BYTE_W-1:0] rdata
);
    logic              take;
    logic [BYTE_W-1:0] rd_lo, rd_hi;
    logic              smp_f0, smp_f1, smp_rd;

    assign take   = req_valid && (cyc_e'(req_kind) != CYC_IDLE);
    assign smp_f0 = (cur.kind == CYC_FETCH) && is_last(phase, PSEN_A, PSEN_LEN);
    assign smp_f1 = (cur.kind == CYC_FETCH) && is_last(phase, PSEN_B, PSEN_LEN);
    assign smp_rd = (cur.kind == CYC_READ)  && is_last(phase, STB_AT, STB_LEN);
    assign rdata  = {rd_hi, rd_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '{kind: CYC_IDLE, addr: '0, wdata: '0};
            done  <= 1'b0;
            rd_lo <= '0;
            rd_hi <= '0;
        end else begin
            done <= last && (cur.kind != CYC_IDLE);
            if (last) begin
                if (take) cur <= '{kind: cyc_e'(req_kind), addr: req_addr, wdata: req_wdata};
                else      cur.kind <= CYC_IDLE;
            end
            if (smp_f0) rd_lo <= ad_in;
            if (smp_f1) rd_hi <= ad_in;
            if (smp_rd) begin
                rd_lo <= ad_in;
                rd_hi <= '0;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_AT_START: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == '0)); // R10
endmodule

// File: rtl/ebus_wave.sv
module ebus_wave
    import ebus_pkg::*;
(
    input  logic [PH_W-1:0]   phase,
    input  xfer_t             cur,
    input  logic              ale_quiet,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] ahi_out
);
    logic              acc, fetch, second;
    logic [ADDR_W-1:0] nxt;

    assign acc    = (cur.kind != CYC_IDLE);
    assign fetch  = (cur.kind == CYC_FETCH);
    assign second = (int'(phase) >= ALE_B);
    assign nxt    = cur.addr + 1'b1;

    always_comb begin
        ale = 1'b0;
        if (in_win(phase, ALE_A, ALE_LEN)) ale = acc || !ale_quiet;
        if (in_win(phase, ALE_B, ALE_LEN)) ale = fetch || (!acc && !ale_quiet);

        psen_n = !(fetch && (in_win(phase, PSEN_A, PSEN_LEN) || in_win(phase, PSEN_B, PSEN_LEN)));
        rd_n   = !((cur.kind == CYC_READ)  && in_win(phase, STB_AT, STB_LEN));
        wr_n   = !((cur.kind == CYC_WRITE) && in_win(phase, STB_AT, STB_LEN));

        ad_oe  = 1'b0;
        ad_out = '0;
        if (acc && in_win(phase, ALE_A, ADR_LEN)) begin
            ad_oe  = 1'b1;
            ad_out = cur.addr[BYTE_W-1:0];
        end else if (fetch && in_win(phase, ALE_B, ADR_LEN)) begin
            ad_oe  = 1'b1;
            ad_out = nxt[BYTE_W-1:0];
        end else if ((cur.kind == CYC_WRITE) && in_win(phase, WD_AT, WD_LEN)) begin
            ad_oe  = 1'b1;
            ad_out = cur.wdata;
        end

        ahi_out = (fetch && second) ? nxt[ADDR_W-1 -: BYTE_W] : cur.addr[ADDR_W-1 -: BYTE_W];
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ale_quiet,
    input  logic                req_valid,
    input  logic [KIND_W-1:0]   req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BYTE_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                done,
    output logic [2*BYTE_W-1:0] rdata,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic [BYTE_W-1:0]   ad_out,
    output logic                ad_oe,
    input  logic [BYTE_W-1:0]   ad_in,
    output logic [BYTE_W-1:0]   ahi_out
);
    logic [PH_W-1:0] phase;
    logic            last;
    xfer_t           cur;

    ebus_phase_ctr i_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (last)
    );

    ebus_xfer_ctl i_ctl (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .last      (last),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .cur       (cur),
        .done      (done),
        .rdata     (rdata)
    );

    ebus_wave i_wave (
        .phase     (phase),
        .cur       (cur),
        .ale_quiet (ale_quiet),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ahi_out   (ahi_out)
    );

    assign req_ready = last;

    AST_READY_SPACED: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R1
    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_ready)); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!psen_n, !rd_n, !wr_n})); // R11
    AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> (!$past(ale) && $past(ale, 2))); // R4
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (!$past(rd_n) && !$past(rd_n, 6) && $past(rd_n, 7))); // R5
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (!$past(wr_n) && !$past(wr_n, 6) && $past(wr_n, 7))); // R6
    AST_WR_DATA_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (!wr_n || $rose(wr_n)) |-> ad_oe); // R6
    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ale_quiet && psen_n && rd_n && wr_n && !ad_oe) |-> !ale); // R8
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale_quiet = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b11;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        req_ready, done, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [15:0] rdata;
    logic [7:0]  ad_out, ahi_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_seq i_ext_bus_seq (
        .clk(clk), .rst(rst), .ale_quiet(ale_quiet), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ahi_out(ahi_out)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // One machine cycle: present the request at the boundary, then check every phase.
    task automatic run_cycle(input logic [1:0] kind, input logic valid, input logic [15:0] addr,
                             input logic [7:0] wd, input logic quiet,
                             input logic [7:0] b0, input logic [7:0] b1, input logic noise);
        logic        acc, f, r, w;
        logic [15:0] nxt;
        string       ts, ta;
        do @(negedge clk); while (!req_ready);
        acc = valid && (kind != 2'b11);
        f = acc && kind == 2'b00;
        r = acc && kind == 2'b01;
        w = acc && kind == 2'b10;
        req_valid = valid; req_kind = kind; req_addr = addr; req_wdata = wd; ale_quiet = quiet;
        if (acc) last_addr = addr;
        nxt = last_addr + 16'd1;
        ts = f ? "R4" : r ? "R5" : w ? "R6" : "R9";
        ta = quiet ? "R8" : "R3";
        @(negedge clk);
        for (int p = 0; p < 12; p++) begin
            logic        e_ale, e_oe;
            logic [7:0]  e_ad, e_hi;
            logic [2:0]  e_stb;
            if (noise) begin
                req_valid = (p != 11); req_kind = 2'b10; req_addr = 16'hBEEF; req_wdata = 8'h77;
            end else begin
                req_valid = 1'b0; req_kind = 2'b11;
            end
            if (f)      ad_in = (p == 5) ? b0 : (p == 11) ? b1 : 8'h5A;
            else if (r) ad_in = (p == 10) ? b0 : ~b0;
            else        ad_in = 8'h00;
            e_ale = ((p == 0 || p == 1) && (acc || !quiet)) ||
                    ((p == 6 || p == 7) && (f || (!acc && !quiet)));
            e_stb = {!(f && ((p >= 3 && p <= 5) || p >= 9)),
                     !(r && p >= 5 && p <= 10),
                     !(w && p >= 5 && p <= 10)};
            e_oe = 1'b0; e_ad = 8'h00;
            if (acc && p <= 2)                begin e_oe = 1'b1; e_ad = last_addr[7:0]; end
            else if (f && p >= 6 && p <= 8)   begin e_oe = 1'b1; e_ad = nxt[7:0]; end
            else if (w && p >= 4)             begin e_oe = 1'b1; e_ad = wd; end
            e_hi = (f && p >= 6) ? nxt[15:8] : last_addr[15:8];
            chk(ta, $sformatf("ale phase %0d", p), 32'(ale), 32'(e_ale));
            chk(ts, $sformatf("strobes phase %0d", p), 32'({psen_n, rd_n, wr_n}), 32'(e_stb));
            chk(ts, $sformatf("ad_oe phase %0d", p), 32'(ad_oe), 32'(e_oe));
            if (e_oe) chk(ts, $sformatf("ad_out phase %0d", p), 32'(ad_out), 32'(e_ad));
            chk("R7", $sformatf("ahi_out phase %0d", p), 32'(ahi_out), 32'(e_hi));
            chk("R11", "single strobe", 32'($countones({!psen_n, !rd_n, !wr_n}) <= 1), 32'd1);
            chk("R9", $sformatf("ready phase %0d", p), 32'(req_ready), 32'(p == 11));
            if (p == 11) begin req_valid = 1'b0; req_kind = 2'b11; end
            @(negedge clk);
        end
        chk("R10", "done after cycle", 32'(done), 32'(acc));
        if (f) chk("R10", "fetch rdata", 32'(rdata), 32'({b1, b0}));
        if (r) chk("R10", "read rdata", 32'(rdata), 32'({8'h00, b0}));
        @(negedge clk);
        chk("R10", "done one clock", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        chk("R2", "strobes in reset", 32'({psen_n, rd_n, wr_n}), 32'h7);
        chk("R2", "done in reset", 32'(done), 32'd0);
        chk("R2", "ad_oe in reset", 32'(ad_oe), 32'd0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!req_ready && n < 40);
        chk("R1", "clocks to first ready", 32'(n), 32'd11);
        n = 0;
        do begin @(negedge clk); n++; end while (!req_ready && n < 40);
        chk("R1", "ready spacing", 32'(n), 32'd12);
    endtask

    task automatic t_fetch_carry();   // R4 R7: second half crosses a 256-byte boundary
        run_cycle(2'b00, 1'b1, 16'h12FF, 8'h00, 1'b0, 8'hA1, 8'hB2, 1'b0);
    endtask

    task automatic t_fetch_quiet();   // R8
        run_cycle(2'b00, 1'b1, 16'h4010, 8'h00, 1'b1, 8'h3E, 8'hC4, 1'b0);
    endtask

    task automatic t_read();          // R5
        run_cycle(2'b01, 1'b1, 16'hA55A, 8'h00, 1'b0, 8'h3C, 8'h00, 1'b0);
    endtask

    task automatic t_write_quiet();   // R6 R8
        run_cycle(2'b10, 1'b1, 16'h0080, 8'hC3, 1'b1, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_idle();          // R3 R8
        run_cycle(2'b11, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        run_cycle(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_ignore();        // R9: reserved kind, then mid-cycle requests
        run_cycle(2'b11, 1'b1, 16'h5555, 8'h99, 1'b0, 8'h00, 8'h00, 1'b1);
        run_cycle(2'b11, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fetch_carry();
        t_read();
        t_write_quiet();
        t_fetch_quiet();
        t_idle();
        t_ignore();
        t_read();
        finish_run();
    end
endmodule